// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a synthesizable behavioural model of a synchronous static RAM whose read path has no output register. Address, control and write data are captured on the rising clock edge, and the word at the captured address reaches the data outputs combinationally in the same cycle. Words are 18 bits wide and split into two 9-bit byte lanes. The depth is set by an address-width parameter. A full-size part uses 20 address bits, and the default is smaller so that simulation stays light.

An access starts from one of two active-low address strobes. A start from the processor strobe is always a read. A start from the controller strobe samples the write controls on the same edge and becomes either a read or a write. After a start, a 2-bit burst counter steps through four words when the advance input is low. The order is linear or interleaved, chosen by a mode pin. Writes inside a burst use either a global write, which covers all 18 bits, or per-lane writes, which need a byte-write enable together with each lane's strobe. An asynchronous output enable gates the data outputs. A drive flag shows when the outputs are driven; when the flag is low the data bus reads as zero, which stands for high impedance.

Top module: `sram_ft_burst`

## Requirements
- R1: On an edge with proc_strb_n low, ce_main_n low, ce_aux high and ce_aux_n low, a read burst starts at addr_i. In the same cycle after that edge, rdata_o shows the word at addr_i and rdata_drv is high, as long as oe_n is low. The write controls have no effect on that edge.
- R2: On an edge with proc_strb_n high (or ce_main_n high), ctrl_strb_n low and the device selected, a burst starts at addr_i. That edge is a write if gwr_n is low, or if bwr_n is low and any lane_wr_n bit is low. Otherwise it is a read.
- R3: When ce_main_n is high, proc_strb_n is ignored and the edge behaves as if proc_strb_n were high. A running burst continues, and a controller strobe start is still evaluated.
- R4: The device is selected only when ce_main_n is low, ce_aux is high and ce_aux_n is low. A start on a deselected edge ends the burst, and rdata_drv stays low until the next selected start.
- R5: A write with gwr_n low writes all 18 bits, whatever bwr_n and lane_wr_n are.
- R6: With gwr_n high, lane k (lane 0 = bits 8:0, lane 1 = bits 17:9) is written only when bwr_n is low and lane_wr_n[k] is low. With bwr_n high, nothing is written.
- R7: lane_wr_n and the write enables are ignored on an edge where the processor strobe takes effect. Nothing is written, and the outputs are not blanked.
- R8: On any other edge, if any lane_wr_n bit is low or a write takes place, rdata_drv is low for the following cycle, whatever oe_n is.
- R9: On a continuing edge (no start) with adv_n low, the burst counter steps by one and wraps after four words. adv_n is ignored on start edges.
- R10: The burst address keeps the upper address bits of the start address. The low two bits are (start + count) mod 4 when linear_burst is 1, and start XOR count when linear_burst is 0.
- R11: When oe_n is high, rdata_drv is low and rdata_o is zero in the same cycle, without waiting for a clock edge.
- R12: A write on a continuing edge goes to the burst address that results after this edge's advance.
- R13: After synchronous reset, no burst is active and rdata_drv is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | AW | Start address |
| proc_strb_n | input | 1 | Processor address strobe, active low, read start |
| ctrl_strb_n | input | 1 | Controller address strobe, active low, read or write start |
| adv_n | input | 1 | Burst advance, active low |
| ce_main_n | input | 1 | Master chip enable, active low |
| ce_aux | input | 1 | Secondary chip enable, active high |
| ce_aux_n | input | 1 | Secondary chip enable, active low |
| gwr_n | input | 1 | Global write, active low |
| bwr_n | input | 1 | Byte-write enable, active low |
| lane_wr_n | input | LANES | Per-lane write strobes, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| linear_burst | input | 1 | 1 selects linear burst order, 0 selects interleaved |
| wdata_i | input | LANES*LANE_W | Write data |
| rdata_o | output | LANES*LANE_W | Read data, zero when not driven |
| rdata_drv | output | 1 | High when the read data outputs are driven |

## Verification
The bench goes after the edges where one strobe overrides another. A processor start that carries asserted write strobes must neither write nor blank the bus; a design that honoured those strobes would corrupt memory or drop a read. A processor strobe blocked by the master enable must let the burst run on, and a deselected controller start must end it; a design that treated the two strobes alike would keep driving the bus or would restart a burst. Burst wrap-around is checked in both orders, together with the advance-before-write rule for continuation writes; a design that wrote before advancing would leave each word one address early. Lane masks are checked on their own and under the global write, and the output enable is checked between clock edges.

// File: rtl/sram_ft_pkg.sv
`timescale 1ns/1ps
package sram_ft_pkg;
  localparam int BURST_W = 2;
  typedef logic [BURST_W-1:0] boff_t;

  typedef enum logic {
    ORDER_INTERLEAVED = 1'b0,
    ORDER_LINEAR      = 1'b1
  } burst_order_e;

  // Low address bits of the current burst beat.
  function automatic boff_t burst_offset(input boff_t start, input boff_t cnt,
                                         input burst_order_e order);
    boff_t r;
    if (order == ORDER_LINEAR) r = boff_t'(start + cnt);
    else                       r = start ^ cnt;
    return r;
  endfunction
endpackage

// File: rtl/sram_ctl_decode.sv
`timescale 1ns/1ps
module sram_ctl_decode #(
  parameter int LANES = 2
) (
  input  logic             proc_strb_n,
  input  logic             ctrl_strb_n,
  input  logic             adv_n,
  input  logic             ce_main_n,
  input  logic             ce_aux,
  input  logic             ce_aux_n,
  input  logic             gwr_n,
  input  logic             bwr_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic             active_q,
  output logic             load,
  output logic             desel,
  output logic             step,
  output logic [LANES-1:0] wr_mask,
  output logic             blank_set
);
  logic selected, proc_go, ctrl_go, start, cont;
  logic [LANES-1:0] lane_req;

  always_comb begin
    selected = !ce_main_n && ce_aux && !ce_aux_n;
    // master enable gates only the processor strobe
    proc_go  = !proc_strb_n && !ce_main_n;
    ctrl_go  = !proc_go && !ctrl_strb_n;
    start    = proc_go || ctrl_go;
    load     = start && selected;
    desel    = start && !selected;
    cont     = !start && active_q;
    step     = cont && !adv_n;
    if (!gwr_n)      lane_req = '1;
    else if (!bwr_n) lane_req = ~lane_wr_n;
    else             lane_req = '0;
    wr_mask   = ((ctrl_go && selected) || cont) ? lane_req : '0;
    blank_set = !proc_go && ((lane_wr_n != '1) || (wr_mask != '0));
  end
endmodule

// File: rtl/sram_burst_seq.sv
`timescale 1ns/1ps
module sram_burst_seq
  import sram_ft_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          desel,
  input  logic          step,
  input  logic          blank_set,
  input  burst_order_e  order,
  input  logic [AW-1:0] addr_in,
  output logic          active_q,
  output logic          blank_q,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] nxt_addr
);
  logic [AW-1:0] base_q, base_nxt;
  boff_t         cnt_q, cnt_nxt;

  always_comb begin
    base_nxt = load ? addr_in : base_q;
    if (load)      cnt_nxt = '0;
    else if (step) cnt_nxt = boff_t'(cnt_q + 1'b1);
    else           cnt_nxt = cnt_q;
    cur_addr = {base_q[AW-1:BURST_W],
                burst_offset(base_q[BURST_W-1:0], cnt_q, order)};
    nxt_addr = {base_nxt[AW-1:BURST_W],
                burst_offset(base_nxt[BURST_W-1:0], cnt_nxt, order)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      blank_q  <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
    end else begin
      if (load)       active_q <= 1'b1;
      else if (desel) active_q <= 1'b0;
      base_q  <= base_nxt;
      cnt_q   <= cnt_nxt;
      blank_q <= blank_set;
    end
  end

  AST_STEP_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (cnt_q == boff_t'($past(cnt_q) + 1'b1))); // R9
  AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load |=> (cur_addr[AW-1:BURST_W] == $past(cur_addr[AW-1:BURST_W]))); // R10
  AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (rst)
    load |=> (cur_addr == $past(addr_in))); // R1
  AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (rst)
    desel |=> !active_q); // R4
endmodule

// File: rtl/sram_lane_array.sv
`timescale 1ns/1ps
module sram_lane_array #(
  parameter int AW     = 10,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we,
  input  logic [AW-1:0]           waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [AW-1:0]           raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
    end
    // flow-through: asynchronous read of the registered address
    assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
  end
endmodule

// File: rtl/sram_out_drive.sv
`timescale 1ns/1ps
module sram_out_drive #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         oe_n,
  input  logic         active_q,
  input  logic         blank_q,
  input  logic [W-1:0] rdata,
  output logic [W-1:0] rdata_o,
  output logic         rdata_drv
);
  always_comb begin
    rdata_drv = !oe_n && active_q && !blank_q;
    rdata_o   = rdata_drv ? rdata : '0;
  end

  AST_OE_QUIET: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> (!rdata_drv && rdata_o == '0)); // R11
endmodule

// File: rtl/sram_ft_burst.sv
`timescale 1ns/1ps
module sram_ft_burst
  import sram_ft_pkg::*;
#(
  parameter int AW     = 10,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [AW-1:0]           addr_i,
  input  logic                    proc_strb_n,
  input  logic                    ctrl_strb_n,
  input  logic                    adv_n,
  input  logic                    ce_main_n,
  input  logic                    ce_aux,
  input  logic                    ce_aux_n,
  input  logic                    gwr_n,
  input  logic                    bwr_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    oe_n,
  input  logic                    linear_burst,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    rdata_drv
);
  localparam int W = LANES * LANE_W;

  logic             load, desel, step, blank_set;
  logic [LANES-1:0] wr_mask;
  logic             active_q, blank_q;
  logic [AW-1:0]    cur_addr, nxt_addr;
  logic [W-1:0]     arr_rdata;
  burst_order_e     order;

  assign order = linear_burst ? ORDER_LINEAR : ORDER_INTERLEAVED;

  sram_ctl_decode #(.LANES(LANES)) u_dec (
    .proc_strb_n(proc_strb_n), .ctrl_strb_n(ctrl_strb_n), .adv_n(adv_n),
    .ce_main_n(ce_main_n), .ce_aux(ce_aux), .ce_aux_n(ce_aux_n),
    .gwr_n(gwr_n), .bwr_n(bwr_n), .lane_wr_n(lane_wr_n),
    .active_q(active_q), .load(load), .desel(desel), .step(step),
    .wr_mask(wr_mask), .blank_set(blank_set)
  );

  sram_burst_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst(rst), .load(load), .desel(desel), .step(step),
    .blank_set(blank_set), .order(order), .addr_in(addr_i),
    .active_q(active_q), .blank_q(blank_q),
    .cur_addr(cur_addr), .nxt_addr(nxt_addr)
  );

  sram_lane_array #(.AW(AW), .LANE_W(LANE_W), .LANES(LANES)) u_arr (
    .clk(clk), .we(wr_mask), .waddr(nxt_addr), .wdata(wdata_i),
    .raddr(cur_addr), .rdata(arr_rdata)
  );

  sram_out_drive #(.W(W)) u_out (
    .clk(clk), .rst(rst), .oe_n(oe_n), .active_q(active_q),
    .blank_q(blank_q), .rdata(arr_rdata),
    .rdata_o(rdata_o), .rdata_drv(rdata_drv)
  );

  logic sel_chk;
  assign sel_chk = !ce_main_n && ce_aux && !ce_aux_n;

  AST_PROC_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!proc_strb_n && !ce_main_n) |-> (wr_mask == '0)); // R7
  AST_LANE_BLANK: assert property (@(posedge clk) disable iff (rst)
    (proc_strb_n && lane_wr_n != '1) |=> !rdata_drv); // R8
  AST_GLOBAL_ALL: assert property (@(posedge clk) disable iff (rst)
    (!gwr_n && wr_mask != '0) |-> (wr_mask == '1)); // R5
  AST_BYTE_GATE: assert property (@(posedge clk) disable iff (rst)
    (gwr_n && bwr_n) |-> (wr_mask == '0)); // R6
  AST_MAIN_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (!proc_strb_n && ce_main_n && ctrl_strb_n && !active_q) |=> !rdata_drv); // R3
  AST_DESEL_OFF: assert property (@(posedge clk) disable iff (rst)
    ((!ctrl_strb_n || (!proc_strb_n && !ce_main_n)) && !sel_chk) |=> !rdata_drv); // R4
endmodule

// File: tb/sim_sram_ft_burst.sv
`timescale 1ns/1ps
module sim_sram_ft_burst;
  localparam int AW = 10;
  localparam int W  = 18;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr_i;
  logic          proc_strb_n, ctrl_strb_n, adv_n, ce_main_n, ce_aux, ce_aux_n;
  logic          gwr_n, bwr_n, oe_n, linear_burst;
  logic [1:0]    lane_wr_n;
  logic [W-1:0]  wdata_i, rdata_o;
  logic          rdata_drv;

  always #2.5 clk = ~clk;

  sram_ft_burst #(.AW(AW), .LANE_W(9), .LANES(2)) u0 (
    .clk(clk), .rst(rst), .addr_i(addr_i), .proc_strb_n(proc_strb_n),
    .ctrl_strb_n(ctrl_strb_n), .adv_n(adv_n), .ce_main_n(ce_main_n),
    .ce_aux(ce_aux), .ce_aux_n(ce_aux_n), .gwr_n(gwr_n), .bwr_n(bwr_n),
    .lane_wr_n(lane_wr_n), .oe_n(oe_n), .linear_burst(linear_burst),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .rdata_drv(rdata_drv)
  );

  // reference model state
  logic [W-1:0] mm [DEPTH];
  bit           known [DEPTH];
  bit           m_act, m_blank;
  int           m_base, m_cnt;
  int           n_chk = 0, n_fail = 0;

  function automatic int model_addr();
    int lo;
    if (linear_burst) lo = ((m_base & 3) + m_cnt) & 3;
    else              lo = (m_base & 3) ^ m_cnt;
    return (m_base & ~3) | lo;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_write(input int a, input bit [1:0] lanes);
    if (lanes[0]) mm[a][8:0]  = wdata_i[8:0];
    if (lanes[1]) mm[a][17:9] = wdata_i[17:9];
    if (lanes == 2'b11) known[a] = 1'b1;
  endtask

  task automatic model_update();
    bit sel, pgo, cgo, wrote;
    bit [1:0] lanes;
    wrote = 1'b0;
    if (rst) begin
      m_act = 0; m_blank = 0; m_base = 0; m_cnt = 0;
      return;
    end
    sel = !ce_main_n && ce_aux && !ce_aux_n;
    pgo = !proc_strb_n && !ce_main_n;
    cgo = !pgo && !ctrl_strb_n;
    if (!gwr_n) lanes = 2'b11;
    else if (!bwr_n) lanes = ~lane_wr_n;
    else lanes = 2'b00;
    if (pgo || cgo) begin
      if (sel) begin
        m_act = 1; m_base = int'(addr_i); m_cnt = 0;
        if (cgo && lanes != 0) begin model_write(m_base, lanes); wrote = 1; end
      end else m_act = 0;
    end else if (m_act) begin
      if (!adv_n) m_cnt = (m_cnt + 1) & 3;
      if (lanes != 0) begin model_write(model_addr(), lanes); wrote = 1; end
    end
    m_blank = !pgo && ((lane_wr_n != 2'b11) || wrote);
  endtask

  task automatic compare(input string tag);
    bit e_drv;
    int a;
    e_drv = !oe_n && m_act && !m_blank;
    chk(tag, "rdata_drv", 32'(rdata_drv), 32'(e_drv));
    if (!e_drv) chk(tag, "rdata_o idle", 32'(rdata_o), 32'd0);
    else begin
      a = model_addr();
      if (known[a]) chk(tag, "rdata_o", 32'(rdata_o), 32'(mm[a]));
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    model_update();
    #1;
    compare(tag);
  endtask

  task automatic idle();
    addr_i = '0; proc_strb_n = 1; ctrl_strb_n = 1; adv_n = 1;
    ce_main_n = 0; ce_aux = 1; ce_aux_n = 0; gwr_n = 1; bwr_n = 1;
    lane_wr_n = 2'b11; wdata_i = '0;
  endtask

  function automatic logic [W-1:0] pat(input int a);
    return W'(18'h15000 ^ (a * 37));
  endfunction

  // controller-strobe global-write fill of four words, advance each beat
  task automatic fill4(input int a0, input string tag);
    idle(); ctrl_strb_n = 0; gwr_n = 0; addr_i = AW'(a0); wdata_i = pat(a0);
    tick(tag);
    for (int i = 1; i < 4; i++) begin
      idle(); gwr_n = 0; adv_n = 0;
      if (linear_burst) wdata_i = pat((a0 & ~3) | (((a0 & 3) + i) & 3));
      else              wdata_i = pat((a0 & ~3) | ((a0 & 3) ^ i));
      tick(tag);
    end
  endtask

  initial begin
    #900000;
    n_chk++; n_fail++;
    $display("FAIL R13 watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle(); oe_n = 0; linear_burst = 1;
    rst = 1;
    for (int i = 0; i < 3; i++) tick("R13");
    chk("R13", "drv after reset", 32'(rdata_drv), 32'd0);
    rst = 0;
    tick("R13");

    // R5 / R12 / R2: linear fill 0x40..0x43
    fill4(10'h40, "R12");
    idle(); tick("R2");
    // R2: controller read start (write controls inactive)
    idle(); ctrl_strb_n = 0; addr_i = 10'h42; tick("R2");
    chk("R2", "ctrl read data", 32'(rdata_o), 32'(pat(10'h42)));

    // R1 / R7 / R9: processor start with write controls asserted and adv low
    idle(); proc_strb_n = 0; addr_i = 10'h41; gwr_n = 0; bwr_n = 0;
    lane_wr_n = 2'b00; adv_n = 0; wdata_i = 18'h3FFFF;
    tick("R7");
    chk("R1", "flow-through data", 32'(rdata_o), 32'(pat(10'h41)));
    chk("R7", "drv on proc edge", 32'(rdata_drv), 32'd1);
    for (int i = 0; i < 4; i++) begin idle(); adv_n = 0; tick("R9"); end
    chk("R10", "linear wrap", 32'(rdata_o), 32'(pat(10'h41)));

    // R10: interleaved fill and read
    linear_burst = 0;
    fill4(10'h44, "R10");
    idle(); proc_strb_n = 0; addr_i = 10'h46; tick("R10");
    idle(); adv_n = 0; tick("R10");
    chk("R10", "interleave beat1", 32'(rdata_o), 32'(pat(10'h47)));
    idle(); adv_n = 0; tick("R10");
    chk("R10", "interleave beat2", 32'(rdata_o), 32'(pat(10'h44)));
    idle(); adv_n = 0; tick("R10");
    linear_burst = 1;

    // R6 / R8: lane writes
    idle(); ctrl_strb_n = 0; addr_i = 10'h42; tick("R6");
    idle(); bwr_n = 0; lane_wr_n = 2'b10; wdata_i = 18'h3FFFF; tick("R8");
    chk("R8", "blank after lane write", 32'(rdata_drv), 32'd0);
    idle(); tick("R6");
    chk("R6", "lane0 only", 32'(rdata_o), 32'({pat(10'h42)[17:9], 9'h1FF}));
    idle(); lane_wr_n = 2'b00; wdata_i = 18'h0; tick("R6");
    chk("R8", "blank with bwr_n high", 32'(rdata_drv), 32'd0);
    idle(); tick("R6");
    chk("R6", "no write when bwr_n high", 32'(rdata_o),
        32'({pat(10'h42)[17:9], 9'h1FF}));
    idle(); bwr_n = 0; lane_wr_n = 2'b01; wdata_i = 18'h0; tick("R6");
    idle(); tick("R6");
    chk("R6", "lane1 only", 32'(rdata_o), 32'({9'h000, 9'h1FF}));
    idle(); gwr_n = 0; bwr_n = 1; lane_wr_n = 2'b11; wdata_i = pat(10'h42);
    tick("R5");
    idle(); tick("R5");
    chk("R5", "global restore", 32'(rdata_o), 32'(pat(10'h42)));

    // R11: asynchronous output enable
    oe_n = 1; #1;
    chk("R11", "drv async off", 32'(rdata_drv), 32'd0);
    chk("R11", "data async zero", 32'(rdata_o), 32'd0);
    tick("R11");
    oe_n = 0; #1;
    chk("R11", "drv async on", 32'(rdata_drv), 32'd1);

    // R3: blocked processor strobe continues the burst
    idle(); proc_strb_n = 0; addr_i = 10'h40; tick("R3");
    idle(); proc_strb_n = 0; ce_main_n = 1; adv_n = 0; addr_i = 10'h00; tick("R3");
    chk("R3", "burst continues", 32'(rdata_o), 32'(pat(10'h41)));
    // R4: deselected controller start ends burst
    idle(); proc_strb_n = 0; ce_main_n = 1; ctrl_strb_n = 0; tick("R4");
    chk("R4", "deselected", 32'(rdata_drv), 32'd0);
    idle(); adv_n = 0; tick("R4");
    idle(); proc_strb_n = 0; addr_i = 10'h43; tick("R1");
    idle(); proc_strb_n = 0; ce_aux = 0; tick("R4");
    chk("R4", "aux deselect", 32'(rdata_drv), 32'd0);

    // mixed stimulus against the model
    for (int i = 0; i < 500; i++) begin
      addr_i       = AW'(10'h40 + ($urandom % 16));
      proc_strb_n  = ($urandom % 4) != 0;
      ctrl_strb_n  = ($urandom % 4) != 0;
      adv_n        = $urandom % 2;
      ce_main_n    = ($urandom % 8) == 0;
      ce_aux       = ($urandom % 8) != 0;
      ce_aux_n     = ($urandom % 8) == 0;
      gwr_n        = ($urandom % 4) != 0;
      bwr_n        = $urandom % 2;
      lane_wr_n    = ($urandom % 2) ? 2'b11 : 2'($urandom);
      oe_n         = ($urandom % 8) == 0;
      linear_burst = $urandom % 2;
      wdata_i      = W'($urandom);
      tick("R2");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule